// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a four-beat burst. When the load strobe is sampled low, the block captures a full starting address. The two lowest bits become the burst origin, and the rest are held unchanged for the whole burst. On each later rising edge where the advance input is sampled low, the beat count steps by one. On edges where advance is high, the current address is held, which gives a wait state.

The output low bits are computed from the origin and the beat count. A static order input chooses between two formulas: the origin plus the count modulo four (linear order), or the origin XOR the count (interleaved order). After the fourth beat the count wraps to zero, so the address returns to the origin. A new load at any point restarts the burst from the new address.

The block sits between a bus controller and a memory array. The array is addressed from `seq_addr`, and `seq_beat` tells the data path which beat of the burst is current.

Top module: `burst_seq`

## Requirements
- R1: After reset, `seq_addr` is 0 and `seq_beat` is 0. Until the first load, a low on `adv_n` changes neither output.
- R2: On the edge where `load_n` is sampled low, `seq_addr` takes the value of `ext_addr`, and `seq_beat` becomes 0 after that edge.
- R3: On an edge where `load_n` is low, `adv_n` is ignored. `seq_beat` is 0 after that edge whether `adv_n` was low or high.
- R4: On an edge where `load_n` is high, `adv_n` is low and a burst has been loaded, `seq_beat` becomes the previous value plus one, modulo 4.
- R5: On an edge where `load_n` and `adv_n` are both high, `seq_addr` and `seq_beat` keep their values (wait state).
- R6: With `order_il` = 0 (linear order), the low two bits of `seq_addr` equal (origin + `seq_beat`) mod 4. For origin 01 this gives the order 01, 10, 11, 00.
- R7: With `order_il` = 1 (interleaved order), the low two bits of `seq_addr` equal origin XOR `seq_beat`. For origin 01 this gives the order 01, 00, 11, 10.
- R8: Between loads, bits `ADDR_W-1:2` of `seq_addr` stay equal to the matching bits of the loaded address.
- R9: After four advances, `seq_beat` is 0 again and the low bits of `seq_addr` equal the origin.
- R10: A load in the middle of a burst restarts the burst. The new address appears with `seq_beat` = 0, and later advances follow the new origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_n | input | 1 | Active-low load strobe; captures `ext_addr` |
| adv_n | input | 1 | Active-low advance; steps the beat when no load occurs |
| order_il | input | 1 | Static order select: 1 = interleaved, 0 = linear |
| ext_addr | input | ADDR_W | Starting word address |
| seq_addr | output | ADDR_W | Current burst word address |
| seq_beat | output | 2 | Current beat index, 0 to 3 |

## Verification
The order checks assume that `order_il` is held steady across the edge being checked. The bench therefore changes it only between bursts, and the assertions skip any cycle where it moved. The load and advance checks assume that `load_n` and `adv_n` are valid binary values at every sampled edge once the internal reset has been released. The bench drives every input on the falling edge and keeps `load_n` high until that release is complete.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  localparam int BEATS  = 1 << BEAT_W;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} order_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  adv,
  output beat_t beat,
  output logic  active
);
  beat_t cnt_q, cnt_d;
  logic  act_q, act_d;
  logic  en;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (adv && act_q) begin
      cnt_d = cnt_q + beat_t'(1);
    end
  end

  assign en = load | (adv & act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign beat   = cnt_q;
  assign active = act_q;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
(
  input  order_e order,
  input  beat_t  origin,
  input  beat_t  beat,
  output beat_t  low
);
  beat_t lin_v [BEATS];
  beat_t ilv_v [BEATS];

  for (genvar k = 0; k < BEATS; k++) begin : g_beat
    assign lin_v[k] = origin + beat_t'(k);
    assign ilv_v[k] = origin ^ beat_t'(k);
  end

  always_comb begin
    if (order == ORD_INTERLEAVE) low = ilv_v[beat];
    else                         low = lin_v[beat];
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              adv_n,
  input  logic              order_il,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [1:0]        seq_beat
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic            rst_s_n;
  logic            load, adv, active;
  beat_t           beat, origin_q, origin_d, low;
  logic [UP_W-1:0] upper_q, upper_d;
  order_e          order;

  burst_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  assign load  = ~load_n;
  assign adv   = ~adv_n;
  assign order = order_e'(order_il);

  burst_beat_ctr u_ctr (
    .clk(clk), .rst_n(rst_s_n), .load(load), .adv(adv),
    .beat(beat), .active(active)
  );

  always_comb begin
    origin_d = origin_q;
    upper_d  = upper_q;
    if (load) begin
      origin_d = ext_addr[BEAT_W-1:0];
      upper_d  = ext_addr[ADDR_W-1:BEAT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      origin_q <= '0;
      upper_q  <= '0;
    end else if (load) begin
      origin_q <= origin_d;
      upper_q  <= upper_d;
    end
  end

  burst_order_map u_map (
    .order(order), .origin(origin_q), .beat(beat), .low(low)
  );

  assign seq_addr = {upper_q, low};
  assign seq_beat = beat;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              load_n,
  input logic              adv_n,
  input logic              order_il,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] seq_addr,
  input logic [1:0]        seq_beat
);
  logic seen_load;
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)      seen_load <= 1'b0;
    else if (!load_n) seen_load <= 1'b1;
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (!seen_load && load_n) |=> (seq_addr == '0 && seq_beat == 2'd0));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    !load_n |=> (seq_addr == $past(ext_addr)));

  assert_adv_ignored_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (!load_n && !adv_n) |=> (seq_beat == 2'd0));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (load_n && !adv_n && seen_load) |=> (seq_beat == $past(seq_beat) + 2'd1));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (load_n && adv_n) |=> ($stable(seq_addr) && $stable(seq_beat)));

  assert_linear_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (load_n && !order_il) |=> (!order_il ->
      ((seq_addr[1:0] - seq_beat) == $past(seq_addr[1:0] - seq_beat))));

  assert_interleave_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (load_n && order_il) |=> (order_il ->
      ((seq_addr[1:0] ^ seq_beat) == $past(seq_addr[1:0] ^ seq_beat))));

  assert_upper_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    load_n |=> $stable(seq_addr[ADDR_W-1:2]));
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_ok(rst_s_n), .load_n(load_n), .adv_n(adv_n),
  .order_il(order_il), .ext_addr(ext_addr), .seq_addr(seq_addr),
  .seq_beat(seq_beat)
);

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_n, adv_n, order_il;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] seq_addr;
  logic [1:0]    seq_beat;

  int n_chk = 0, n_bad = 0;
  logic [1:0]    e_org;
  logic [AW-3:0] e_up;
  int            e_k;

  always #10 clk = ~clk;

  burst_seq #(.ADDR_W(AW)) u_burst_seq (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .adv_n(adv_n),
    .order_il(order_il), .ext_addr(ext_addr), .seq_addr(seq_addr),
    .seq_beat(seq_beat)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_addr();
    logic [1:0] k2;
    logic [1:0] lo;
    k2 = 2'(e_k);
    lo = order_il ? (e_org ^ k2) : (e_org + k2);
    return int'({e_up, lo});
  endfunction

  task automatic step(input logic ld, input logic av, input logic [AW-1:0] a);
    @(negedge clk);
    load_n = ld; adv_n = av; ext_addr = a;
    @(posedge clk); #2;
    if (!ld) begin
      e_org = a[1:0]; e_up = a[AW-1:2]; e_k = 0;
    end else if (!av) begin
      e_k = (e_k + 1) % 4;
    end
  endtask

  task automatic check_state(input string tag);
    cmp({tag, " addr"}, int'(seq_addr), exp_addr());
    cmp({tag, " beat"}, int'(seq_beat), e_k);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_n = 1'b1; adv_n = 1'b1; order_il = 1'b0; ext_addr = '0;
    e_org = '0; e_up = '0; e_k = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    cmp("R1 reset addr", int'(seq_addr), 0);
    cmp("R1 reset beat", int'(seq_beat), 0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, 6'h3f);
      cmp("R1 adv before load addr", int'(seq_addr), 0);
      cmp("R1 adv before load beat", int'(seq_beat), 0);
    end

    // Sweep: both orders, every origin, several upper patterns.
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int u = 0; u < 4; u++) begin
          logic [AW-1:0] a;
          @(negedge clk); order_il = m[0];
          a = AW'(((u * 5 + 3) % 16) * 4 + s);
          step(1'b0, u[0], a);
          cmp("R2 load addr", int'(seq_addr), int'(a));
          cmp("R3 beat after load", int'(seq_beat), 0);
          for (int j = 0; j < 10; j++) begin
            logic hold;
            hold = ((j + u) % 3) == 2;
            step(1'b1, hold, '0);
            if (hold) check_state("R5 hold");
            else if (m == 0) check_state("R6 linear");
            else check_state("R7 interleave");
            cmp("R8 upper", int'(seq_addr[AW-1:2]), int'(a[AW-1:2]));
          end
        end
      end
    end

    // Wrap after four advances.
    for (int m = 0; m < 2; m++) begin
      @(negedge clk); order_il = m[0];
      step(1'b0, 1'b1, 6'h2b);
      for (int j = 0; j < 4; j++) step(1'b1, 1'b0, '0);
      cmp("R9 wrap beat", int'(seq_beat), 0);
      cmp("R9 wrap addr", int'(seq_addr), 'h2b);
    end

    // Reload in the middle of a burst.
    @(negedge clk); order_il = 1'b0;
    step(1'b0, 1'b1, 6'h11);
    step(1'b1, 1'b0, '0);
    step(1'b1, 1'b0, '0);
    step(1'b0, 1'b0, 6'h26);
    cmp("R10 reload addr", int'(seq_addr), 'h26);
    cmp("R10 reload beat", int'(seq_beat), 0);
    step(1'b1, 1'b0, '0);
    cmp("R10 after reload addr", int'(seq_addr), 'h27);
    step(1'b1, 1'b0, '0);
    cmp("R10 linear wrap low", int'(seq_addr), 'h24);
    cmp("R4 beat count", int'(seq_beat), 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule